// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

The block is a memory-mapped mailbox through which several processors pass 32-bit words to each other. A set of small hardware queues sits behind a 32-bit register bus. A write to a queue's message register adds a word at its tail. A read of the same register removes the word at its head. Each queue also has a register that shows whether it is full and a register that gives its current fill level.

Every processor that uses the mailbox owns a bank of interrupt registers and one interrupt output. The bank has a status word, an enable-set register and an enable-clear register. Each queue drives two level events into every bank: "holds data" and "has room". Software clears a status bit by writing a one to it. If the event condition still holds, the bit is set again. Software arms a user's interrupt by setting bits through the enable-set register and disarms it through the enable-clear register.

Reads are registered. `bus_rdata` takes the selected register's value on the clock edge that samples `bus_rd` and keeps that value until the next read. Writes take effect on the clock edge that samples `bus_wr`. A status bit follows its event level one cycle later.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, every enable word is 0, every interrupt output is low, and the identification register at offset 0x000 reads the parameter `REVISION` (default 0x0001_0200).
- R2: The message register of queue m is at 0x040+4*m. Writes push words and reads pop them in first-in, first-out order. The fill-level register at 0x0C0+4*m returns the number of words held.
- R3: The full-flag register at 0x080+4*m reads 1 while queue m holds `FIFO_DEPTH` words and 0 otherwise. A write to a full queue is discarded and changes neither its contents nor its fill level.
- R4: A read of an empty queue's message register returns 0 and leaves the queue unchanged, so the next word pushed is the next word popped.
- R5: User u's status word is at 0x104+0x10*u. Bit 2*m is queue m's holds-data event and bit 2*m+1 is its has-room event. Each bit is set in every user's bank in the cycle after its condition holds.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a bit's event condition holds in the cycle of the clearing write, the bit stays set.
- R7: Writing the enable-set register at 0x108+0x10*u ORs the written bits into user u's enable word. Writing 1s to the enable-clear register at 0x10C+0x10*u clears those enable bits. Both addresses read back the enable word.
- R8: `irq_o[u]` is high exactly when some bit is set in both user u's status word and user u's enable word. Each user's output is independent of the other users' banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| irq_o | output | NUM_USERS | Interrupt output, one per user |

## Verification
Two functions can act on the same status bit in one cycle: a software clear arriving through the bus, and the queue's level event setting the bit again. The bench provokes this by writing all-ones to a status word while queues still hold data or still have room. It judges the result by reading the word back and comparing it with the value expected from the queue states alone. Cleared bits whose conditions no longer hold must read 0, and bits whose conditions are still true must read 1. The same race is also exercised at the interrupt output: data is popped, the stale holds-data bit is cleared, and the bench checks that the interrupt line falls.

// File: rtl/mbx_pkg.sv
// Package for the mailbox: bus widths, register kinds and address helpers.
// Assumes byte addressing with word-aligned registers.
package mbx_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_IDENT,
        RK_MSG,
        RK_FULL,
        RK_LEVEL,
        RK_STAT,
        RK_ENSET,
        RK_ENCLR
    } reg_kind_e;

    function automatic logic [ADDR_W-1:0] msg_addr(input int m);
        return ADDR_W'(12'h040 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] full_addr(input int m);
        return ADDR_W'(12'h080 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] level_addr(input int m);
        return ADDR_W'(12'h0C0 + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int u);
        return ADDR_W'(12'h104 + 16 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enset_addr(input int u);
        return ADDR_W'(12'h108 + 16 * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enclr_addr(input int u);
        return ADDR_W'(12'h10C + 16 * u);
    endfunction

endpackage

// File: rtl/mbx_queue.sv
// One message queue: a circular buffer with push, pop and a fill counter.
// Assumes DEPTH >= 2. A push to a full queue and a pop of an empty queue
// are ignored. The head word reads as 0 when the queue is empty.
module mbx_queue #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Status of the queue taken from the counter.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Advance the pointers and the counter for accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // Store an accepted word. Storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/mbx_user_bank.sv
// Interrupt bank for one user. It holds a status word and an enable word.
// Status bits are cleared by writing 1 and re-set by level events, and the
// set wins over a clear in the same cycle. The enable word has separate set
// and clear strobes. The interrupt output is the OR of status AND enable.
module mbx_user_bank #(
    parameter int EV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_level,
    input  logic            st_clr,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic [EV_W-1:0] wbits,
    output logic [EV_W-1:0] status,
    output logic [EV_W-1:0] enable,
    output logic            irq
);

    logic [EV_W-1:0] clr_mask;
    logic [EV_W-1:0] set_mask;
    logic [EV_W-1:0] off_mask;

    // Turn the write strobes into bit masks.
    always_comb begin
        clr_mask = st_clr ? wbits : '0;
        set_mask = en_set ? wbits : '0;
        off_mask = en_clr ? wbits : '0;
    end

    // Latch events into status and clear the bits that software acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_mask) | ev_level;
    end

    // Update the enable word from the set and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else
            enable <= (enable | set_mask) & ~off_mask;
    end

    // Drive the interrupt from status bits that are enabled.
    always_comb begin
        irq = |(status & enable);
    end

endmodule

// File: rtl/mbx_decode.sv
// Address decoder. It turns a bus strobe and address into one-hot
// per-queue and per-user strobes, plus a register kind and index for the
// read multiplexer. Addresses that match no register give RK_NONE.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_FIFOS = 4,
    parameter int NUM_USERS = 3,
    parameter int IDX_W     = 3
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_FIFOS-1:0] push,
    output logic [NUM_FIFOS-1:0] pop,
    output logic [NUM_USERS-1:0] st_clr,
    output logic [NUM_USERS-1:0] en_set,
    output logic [NUM_USERS-1:0] en_clr,
    output reg_kind_e            sel_kind,
    output logic [IDX_W-1:0]     sel_idx
);

    // Compare the address with every register of every queue and user.
    always_comb begin
        push     = '0;
        pop      = '0;
        st_clr   = '0;
        en_set   = '0;
        en_clr   = '0;
        sel_kind = RK_NONE;
        sel_idx  = '0;
        if (bus_addr == '0)
            sel_kind = RK_IDENT;
        for (int m = 0; m < NUM_FIFOS; m++) begin
            if (bus_addr == msg_addr(m)) begin
                sel_kind = RK_MSG;
                sel_idx  = IDX_W'(m);
                push[m]  = bus_wr;
                pop[m]   = bus_rd;
            end
            if (bus_addr == full_addr(m)) begin
                sel_kind = RK_FULL;
                sel_idx  = IDX_W'(m);
            end
            if (bus_addr == level_addr(m)) begin
                sel_kind = RK_LEVEL;
                sel_idx  = IDX_W'(m);
            end
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (bus_addr == stat_addr(u)) begin
                sel_kind  = RK_STAT;
                sel_idx   = IDX_W'(u);
                st_clr[u] = bus_wr;
            end
            if (bus_addr == enset_addr(u)) begin
                sel_kind  = RK_ENSET;
                sel_idx   = IDX_W'(u);
                en_set[u] = bus_wr;
            end
            if (bus_addr == enclr_addr(u)) begin
                sel_kind  = RK_ENCLR;
                sel_idx   = IDX_W'(u);
                en_clr[u] = bus_wr;
            end
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
// Top of the interprocessor mailbox. It has NUM_FIFOS queues and NUM_USERS
// interrupt banks behind a single-beat register bus. Each queue's holds-data
// and has-room levels go to every bank. Read data is registered on the edge
// that samples bus_rd and held until the next read.
// Assumes at most one of bus_wr and bus_rd is high per cycle, and
// NUM_FIFOS <= 16 so that the event word fits in a bus word.
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS  = 4,
    parameter int          FIFO_DEPTH = 4,
    parameter int          NUM_USERS  = 3,
    parameter logic [31:0] REVISION   = 32'h0001_0200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int EV_W  = 2 * NUM_FIFOS;
    localparam int MAX_N = (NUM_FIFOS > NUM_USERS) ? NUM_FIFOS : NUM_USERS;
    localparam int IDX_W = $clog2(MAX_N + 1);

    logic [NUM_FIFOS-1:0]             push;
    logic [NUM_FIFOS-1:0]             pop;
    logic [NUM_USERS-1:0]             st_clr;
    logic [NUM_USERS-1:0]             en_set;
    logic [NUM_USERS-1:0]             en_clr;
    reg_kind_e                        sel_kind;
    logic [IDX_W-1:0]                 sel_idx;
    logic [NUM_FIFOS-1:0][DATA_W-1:0] fifo_head;
    logic [NUM_FIFOS-1:0][CNT_W-1:0]  fifo_cnt;
    logic [NUM_FIFOS-1:0]             fifo_full;
    logic [NUM_FIFOS-1:0]             fifo_empty;
    logic [EV_W-1:0]                  ev_level;
    logic [NUM_USERS-1:0][EV_W-1:0]   usr_status;
    logic [NUM_USERS-1:0][EV_W-1:0]   usr_enable;
    logic [DATA_W-1:0]                rd_word;

    mbx_decode #(
        .NUM_FIFOS (NUM_FIFOS),
        .NUM_USERS (NUM_USERS),
        .IDX_W     (IDX_W)
    ) decode_i (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .push     (push),
        .pop      (pop),
        .st_clr   (st_clr),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .sel_kind (sel_kind),
        .sel_idx  (sel_idx)
    );

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_queue
        mbx_queue #(
            .DEPTH (FIFO_DEPTH),
            .WIDTH (DATA_W)
        ) queue_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[m]),
            .pop   (pop[m]),
            .wdata (bus_wdata),
            .head  (fifo_head[m]),
            .count (fifo_cnt[m]),
            .full  (fifo_full[m]),
            .empty (fifo_empty[m])
        );

        // Pair the two level events of this queue: holds data, has room.
        always_comb begin
            ev_level[2*m]     = !fifo_empty[m];
            ev_level[2*m + 1] = !fifo_full[m];
        end
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        mbx_user_bank #(
            .EV_W (EV_W)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_level (ev_level),
            .st_clr   (st_clr[u]),
            .en_set   (en_set[u]),
            .en_clr   (en_clr[u]),
            .wbits    (bus_wdata[EV_W-1:0]),
            .status   (usr_status[u]),
            .enable   (usr_enable[u]),
            .irq      (irq_o[u])
        );
    end

    // Select the word of the addressed register for a read.
    always_comb begin
        rd_word = '0;
        case (sel_kind)
            RK_IDENT: rd_word = REVISION;
            RK_MSG, RK_FULL, RK_LEVEL: begin
                for (int m = 0; m < NUM_FIFOS; m++) begin
                    if (sel_idx == IDX_W'(m)) begin
                        if (sel_kind == RK_MSG)
                            rd_word = fifo_head[m];
                        else if (sel_kind == RK_FULL)
                            rd_word = DATA_W'(fifo_full[m]);
                        else
                            rd_word = DATA_W'(fifo_cnt[m]);
                    end
                end
            end
            RK_STAT, RK_ENSET, RK_ENCLR: begin
                for (int u = 0; u < NUM_USERS; u++) begin
                    if (sel_idx == IDX_W'(u)) begin
                        if (sel_kind == RK_STAT)
                            rd_word = DATA_W'(usr_status[u]);
                        else
                            rd_word = DATA_W'(usr_enable[u]);
                    end
                end
            end
            default: rd_word = '0;
        endcase
    end

    // Register the read word and hold it until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
// Property checker for ipc_mailbox. It is attached by bind and observes
// the bus ports, the queue fill levels and the per-user status and enable
// words.
module ipc_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int NUM_FIFOS  = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int NUM_USERS  = 3,
    parameter int CNT_W      = 3,
    parameter int EV_W       = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr,
    input logic                           bus_rd,
    input logic [11:0]                    bus_addr,
    input logic [31:0]                    bus_wdata,
    input logic [NUM_USERS-1:0]           irq_o,
    input logic [NUM_FIFOS-1:0][CNT_W-1:0] fifo_cnt,
    input logic [NUM_USERS-1:0][EV_W-1:0] usr_status,
    input logic [NUM_USERS-1:0][EV_W-1:0] usr_enable
);

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_q
        // R3
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(fifo_cnt[m]) <= FIFO_DEPTH);

        // R2
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(fifo_cnt[m]) - int'($past(fifo_cnt[m]))) <= 1 &&
            (int'($past(fifo_cnt[m])) - int'(fifo_cnt[m])) <= 1);

        // R4
        empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == msg_addr(m) && fifo_cnt[m] == '0)
            |=> fifo_cnt[m] == '0);

        for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
            // R5
            data_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fifo_cnt[m] != '0) |=> usr_status[u][2*m]);
        end
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_usr
        // R8
        quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (usr_enable[u] == '0) |-> !irq_o[u]);

        for (genvar b = 0; b < EV_W; b++) begin : g_bit
            // R7
            en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == enclr_addr(u) && bus_wdata[b])
                |=> !usr_enable[u][b]);
        end
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .NUM_FIFOS  (NUM_FIFOS),
    .FIFO_DEPTH (FIFO_DEPTH),
    .NUM_USERS  (NUM_USERS),
    .CNT_W      (CNT_W),
    .EV_W       (EV_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .fifo_cnt   (fifo_cnt),
    .usr_status (usr_status),
    .usr_enable (usr_enable)
);

// File: tb/ipc_mailbox_tb_top.sv
// Directed bench for ipc_mailbox. Each task covers one scenario and checks
// its own results against values derived from the requirements.
module ipc_mailbox_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NU         = 3;
    localparam int DEPTH      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NU-1:0] irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mailbox dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [11:0] a_msg(int m);   return 12'(12'h040 + 4*m);  endfunction
    function automatic logic [11:0] a_full(int m);  return 12'(12'h080 + 4*m);  endfunction
    function automatic logic [11:0] a_lvl(int m);   return 12'(12'h0C0 + 4*m);  endfunction
    function automatic logic [11:0] a_stat(int u);  return 12'(12'h104 + 16*u); endfunction
    function automatic logic [11:0] a_eset(int u);  return 12'(12'h108 + 16*u); endfunction
    function automatic logic [11:0] a_eclr(int u);  return 12'(12'h10C + 16*u); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write beat, then one idle cycle so that status has followed.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(12'h000, v);  check("R1 ident", v, 32'h0001_0200);
        for (int m = 0; m < 4; m++) begin
            rd(a_lvl(m), v); check("R1 level empty", v, 0);
        end
        for (int u = 0; u < NU; u++) begin
            rd(a_eset(u), v); check("R1 enable zero", v, 0);
        end
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(a_msg(1), 32'hA1A1_0001);
        wr(a_msg(1), 32'hB2B2_0002);
        wr(a_msg(1), 32'hC3C3_0003);
        rd(a_lvl(1), v); check("R2 level 3", v, 3);
        rd(a_msg(1), v); check("R2 pop first", v, 32'hA1A1_0001);
        rd(a_msg(1), v); check("R2 pop second", v, 32'hB2B2_0002);
        rd(a_msg(1), v); check("R2 pop third", v, 32'hC3C3_0003);
        rd(a_lvl(1), v); check("R2 level 0", v, 0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        for (int i = 0; i < DEPTH; i++) wr(a_msg(2), 32'h5500_0000 + i);
        rd(a_full(2), v); check("R3 full flag set", v, 1);
        wr(a_msg(2), 32'hDEAD_BEEF);
        rd(a_lvl(2), v); check("R3 level after dropped write", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            rd(a_msg(2), v); check("R3 contents kept", v, 32'h5500_0000 + i);
        end
        rd(a_full(2), v); check("R3 full flag clear", v, 0);
        rd(a_lvl(2), v); check("R3 drained", v, 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        rd(a_msg(3), v); check("R4 empty read zero", v, 0);
        rd(a_lvl(3), v); check("R4 level stays 0", v, 0);
        wr(a_msg(3), 32'h1234_5678);
        rd(a_msg(3), v); check("R4 pointers intact", v, 32'h1234_5678);
        rd(a_msg(3), v); check("R4 empty again", v, 0);
    endtask

    // Status words; all queues start empty with room (bits 1,3,5,7 = 0xAA).
    task automatic t_status();
        logic [31:0] v;
        for (int u = 0; u < NU; u++) wr(a_stat(u), 32'hFF);
        for (int u = 0; u < NU; u++) begin
            rd(a_stat(u), v); check("R6 level re-sets room bits", v, 32'hAA);
        end
        wr(a_msg(0), 32'h0000_0011);
        for (int u = 0; u < NU; u++) begin
            rd(a_stat(u), v); check("R5 data bit 0 in every bank", v, 32'hAB);
        end
        for (int i = 1; i < DEPTH; i++) wr(a_msg(0), 32'h0000_0011 + i);
        wr(a_stat(0), 32'h02);
        rd(a_stat(0), v); check("R6 clear room bit of full queue", v, 32'hA9);
        rd(a_stat(1), v); check("R5 other bank untouched", v, 32'hAB);
        wr(a_stat(0), 32'h01);
        rd(a_stat(0), v); check("R6 clear lost to held data", v, 32'hA9);
        wr(a_stat(0), 32'h00);
        rd(a_stat(0), v); check("R6 zero write no effect", v, 32'hA9);
        for (int i = 0; i < DEPTH; i++) rd(a_msg(0), v);
        rd(a_stat(0), v); check("R5 room bit back, data bit latched", v, 32'hAB);
        wr(a_stat(0), 32'h01);
        rd(a_stat(0), v); check("R6 clear of stale data bit", v, 32'hAA);
        for (int u = 1; u < NU; u++) wr(a_stat(u), 32'hFF);
        rd(a_stat(2), v); check("R6 full clear keeps live bits", v, 32'hAA);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(a_eset(1), 32'h05);
        rd(a_eset(1), v); check("R7 set", v, 32'h05);
        wr(a_eset(1), 32'h10);
        rd(a_eset(1), v); check("R7 set ORs", v, 32'h15);
        wr(a_eclr(1), 32'h04);
        rd(a_eclr(1), v); check("R7 clear one bit", v, 32'h11);
        rd(a_eset(0), v); check("R7 other user untouched", v, 0);
        wr(a_eclr(1), 32'hFF);
        rd(a_eset(1), v); check("R7 clear all", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R8 no enables no irq", 32'(irq_o), 0);
        wr(a_eset(2), 32'h01);
        check("R8 enabled but no event", 32'(irq_o), 0);
        wr(a_msg(0), 32'h0000_0077);
        check("R8 data event on user 2 only", 32'(irq_o), 32'b100);
        rd(a_msg(0), v);
        @(negedge clk);
        check("R8 latched after pop", 32'(irq_o), 32'b100);
        wr(a_stat(2), 32'h01);
        check("R8 cleared after acknowledge", 32'(irq_o), 0);
        wr(a_eset(0), 32'h02);
        check("R8 room event on user 0", 32'(irq_o), 32'b001);
        wr(a_eclr(0), 32'h02);
        check("R8 disabled", 32'(irq_o), 0);
        wr(a_eclr(2), 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_full();
        t_empty_read();
        t_status();
        t_enable();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule